// File: doc/BRIEF.md
# Serial EEPROM Read Target (I2C, 4 Kbit)

This block is the target side of a two-wire serial memory that holds 512 bytes. A bus master selects the device by a fixed four-bit type code and loads an internal nine-bit address counter with a dummy write. The counter's top bit travels in the slave address byte and the low eight bits follow in a word-address byte. After a repeated start with the read bit set, the target shifts out the addressed byte, most significant bit first. It keeps sending consecutive bytes for as long as the master acknowledges. A master non-acknowledge followed by a stop returns the target to idle.

SCL and SDA are sampled through a two-flop synchronizer on the system clock, which must run at least eight times faster than SCL. SDA is open drain: the block only pulls it low through `sda_oe` and never drives it high. A preload port writes the internal byte array directly, so test setups can fill the memory without a bus write path.

Top module: `i2c_eeprom_reader`

## Requirements
- R1: A start (SDA falling while SCL is high) is recognised at any point, including in the middle of a byte, and restarts reception of a slave address byte. A stop (SDA rising while SCL is high) is also recognised at any point and returns the target to idle with SDA released.
- R2: The slave address byte is acknowledged only when its bits 7..4 equal 1010. With any other code the target gives no acknowledge and ignores the bus until the next start.
- R3: Slave address bits 3..2 are don't-care. Bit 0 is R/W, where 0 means write and 1 means read. Bit 1 is address bit A8 and is taken only from a write-addressed byte; its value in a read-addressed byte has no effect.
- R4: After an acknowledged write address, the next byte is the word address. It is acknowledged, and the counter is loaded with {A8, word byte}.
- R5: An acknowledged read address is followed by the 8 bits at the counter's location, most significant bit first.
- R6: After each transmitted byte the counter advances by one and wraps from 0x1FF to 0x000. When the master acknowledges, the next byte follows at once. A read with no preceding write starts at the counter's current value.
- R7: A master non-acknowledge ends transmission with SDA released. After the following stop the target is idle and SDA stays released.
- R8: A write that ends with a stop after the word address keeps the new counter value. Further bytes in a write are neither acknowledged nor stored.
- R9: The target changes SDA only while SCL is low. It pulls SDA low for the whole ninth clock of each byte it acknowledges.
- R10: After reset, SDA is released and the target is idle.
- R11: A write on the preload port stores a byte at the given address, where a later bus read returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | When 1, pull SDA low |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 9 | Preload byte address |
| pre_data | input | 8 | Preload byte value |

## Verification
The bench runs dummy-write-then-read sequences to random addresses, with random don't-care bits and a random A8 in the read byte. If A8 were taken from the read byte, these sequences would return data from the wrong half of the array. A read that starts at 0x1FF checks the wrap; a counter that carried into a tenth bit, or failed to wrap, would return the wrong second byte. Foreign device codes, data bytes that follow a word address, and starts or stops cut into the middle of a byte are each applied. A design that acknowledged the wrong code, stored the data byte, or kept counting bits across a start would show a wrong acknowledge level or wrong read data.

// File: rtl/i2c_eeprom_reader.sv
module i2c_eeprom_reader #(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       pre_we,
  input  logic [8:0] pre_addr,
  input  logic [7:0] pre_data
);
  localparam int AW = 9;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ACKD, S_WORD, S_ACKW, S_TX, S_MACK, S_SKIP} st_t;

  logic [7:0] mem [DEPTH];
  logic [2:0] scl_p, sda_p;
  st_t        state;
  logic [2:0] bitcnt;
  logic [7:0] sh, tx;
  logic       rx_full, rw, a8, mack;
  logic [AW-1:0] addr;

  wire scl_s = scl_p[1];
  wire scl_q = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_q = sda_p[2];
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire [7:0] rd_byte = mem[addr];

  always_ff @(posedge clk) begin
    if (pre_we) mem[pre_addr] <= pre_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      sda_oe  <= 1'b0;
      bitcnt  <= '0;
      sh      <= '0;
      tx      <= '0;
      rx_full <= 1'b0;
      rw      <= 1'b0;
      a8      <= 1'b0;
      mack    <= 1'b0;
      addr    <= '0;
    end else if (start_det) begin
      state   <= S_DEV;
      bitcnt  <= '0;
      rx_full <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state   <= S_IDLE;
      rx_full <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      case (state)
        S_DEV, S_WORD, S_SKIP: begin
          if (scl_rise) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) rx_full <= 1'b1;
          end else if (scl_fall && rx_full) begin
            rx_full <= 1'b0;
            bitcnt  <= '0;
            if (state == S_DEV) begin
              if (sh[7:4] == DEV_CODE) begin
                sda_oe <= 1'b1;
                rw     <= sh[0];
                if (!sh[0]) a8 <= sh[1];
                state  <= S_ACKD;
              end else begin
                state  <= S_IDLE;
              end
            end else if (state == S_WORD) begin
              sda_oe <= 1'b1;
              addr   <= {a8, sh};
              state  <= S_ACKW;
            end
          end
        end
        S_ACKD: if (scl_fall) begin
          if (rw) begin
            tx     <= rd_byte;
            sda_oe <= ~rd_byte[7];
            bitcnt <= '0;
            state  <= S_TX;
          end else begin
            sda_oe <= 1'b0;
            state  <= S_WORD;
          end
        end
        S_ACKW: if (scl_fall) begin
          sda_oe <= 1'b0;
          state  <= S_SKIP;
        end
        S_TX: if (scl_fall) begin
          if (bitcnt == 3'd7) begin
            sda_oe <= 1'b0;
            addr   <= addr + 1'b1;
            mack   <= 1'b0;
            state  <= S_MACK;
          end else begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
            bitcnt <= bitcnt + 3'd1;
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            if (sda_s) state <= S_IDLE;
            else       mack  <= 1'b1;
          end else if (scl_fall && mack) begin
            mack   <= 1'b0;
            tx     <= rd_byte;
            sda_oe <= ~rd_byte[7];
            bitcnt <= '0;
            state  <= S_TX;
          end
        end
        default: ;
      endcase
    end
  end

  assert_sda_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_s || $past(start_det || stop_det)));

  assert_start_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == S_DEV && bitcnt == 3'd0 && !sda_oe));

  assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == S_IDLE && !sda_oe));

  assert_drive_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> (state inside {S_ACKD, S_ACKW, S_TX}));

  assert_foreign_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEV && scl_fall && rx_full && sh[7:4] != DEV_CODE && !start_det && !stop_det)
      |=> (state == S_IDLE && !sda_oe));

  assert_counter_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TX && scl_fall && bitcnt == 3'd7 && !start_det && !stop_det)
      |=> (addr == $past(addr) + 9'd1));
endmodule

// File: tb/tb_i2c_eeprom_reader.sv
module tb_i2c_eeprom_reader;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_low = 1'b0;
  logic       sda_oe;
  logic       sda_bus;
  logic       pre_we = 1'b0;
  logic [8:0] pre_addr = '0;
  logic [7:0] pre_data = '0;

  assign sda_bus = ~(m_low | sda_oe);

  i2c_eeprom_reader dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data)
  );

  int n_tests = 0;
  int n_fail = 0;
  logic [7:0] model [512];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start;
    m_low = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    m_low = 1'b1; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop;
    scl = 1'b0; m_low = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    m_low = 1'b0; tick(Q);
  endtask

  task automatic send_bit(input bit b);
    m_low = ~b; tick(Q);
    scl = 1'b1; tick(2 * Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output bit b);
    m_low = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    b = sda_bus; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    send_bit(~give_ack);
  endtask

  function automatic logic [7:0] dev_byte(input bit a8, input bit rw, input logic [1:0] dc);
    return {4'b1010, dc, a8, rw};
  endfunction

  task automatic preload(input logic [8:0] a, input logic [7:0] d);
    pre_addr = a; pre_data = d; pre_we = 1'b1; tick(1);
    pre_we = 1'b0;
    model[a] = d;
  endtask

  task automatic set_addr(input logic [8:0] a);
    bit ack;
    bus_start;
    send_byte(dev_byte(a[8], 1'b0, 2'($urandom)), ack);
    chk(ack, "R2 R3 R9 write address ack", ack, 1);
    send_byte(a[7:0], ack);
    chk(ack, "R4 R9 word address ack", ack, 1);
  endtask

  task automatic read_run(input logic [8:0] a, input int n, input string req);
    bit ack;
    logic [7:0] v;
    logic [8:0] p = a;
    bus_start;
    send_byte(dev_byte(1'($urandom), 1'b1, 2'($urandom)), ack);
    chk(ack, "R3 R5 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, v);
      chk(v == model[p], req, v, model[p]);
      p = p + 9'd1;
    end
    bus_stop;
    tick(4);
    chk(sda_oe == 1'b0, "R7 released after stop", sda_oe, 0);
  endtask

  task automatic random_read(input logic [8:0] a, input int n, input string req);
    set_addr(a);
    read_run(a, n, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] v;
    void'($urandom(32'd20240611));
    tick(5);
    chk(sda_oe == 1'b0, "R10 reset released", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);
    chk(sda_oe == 1'b0 && sda_bus == 1'b1, "R10 idle after reset", sda_oe, 0);

    for (int i = 0; i < 512; i++) preload(9'(i), 8'($urandom));

    for (int it = 0; it < 16; it++)
      random_read(9'($urandom), 1 + int'($urandom % 3), "R5 R6 random read");

    random_read(9'h1FF, 3, "R6 wrap 1FF to 000");

    bus_start;
    send_byte(8'b1011_0000, ack);
    chk(!ack, "R2 foreign code not acked", ack, 0);
    send_byte(8'h00, ack);
    chk(!ack, "R2 ignored until start", ack, 0);
    bus_stop;

    bus_start;
    send_byte(8'b0010_0011, ack);
    chk(!ack, "R2 foreign read code not acked", ack, 0);
    bus_stop;

    set_addr(9'h0AB);
    bus_stop;
    read_run(9'h0AB, 1, "R8 address kept after stop");
    read_run(9'h0AC, 2, "R6 current address read");

    set_addr(9'h010);
    send_byte(~model[9'h010], ack);
    chk(!ack, "R8 data byte not acked", ack, 0);
    bus_stop;
    random_read(9'h010, 1, "R8 memory unchanged");

    preload(9'h155, 8'h5A);
    random_read(9'h155, 1, "R11 preload read back");
    preload(9'h0FF, 8'hC3);
    random_read(9'h0FF, 2, "R11 R3 A8 step");

    bus_start;
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    random_read(9'h1A0, 1, "R1 start mid byte");

    bus_start;
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_stop;
    tick(4);
    chk(sda_oe == 1'b0, "R1 stop mid byte idle", sda_oe, 0);
    random_read(9'h033, 1, "R1 after mid-byte stop");

    set_addr(9'h122);
    bus_start;
    send_byte(dev_byte(1'b0, 1'b1, 2'b11), ack);
    chk(ack, "R3 A8 in read byte ignored ack", ack, 1);
    recv_byte(1'b0, v);
    chk(v == model[9'h122], "R3 A8 in read byte ignored", v, model[9'h122]);
    bus_stop;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule